// File: doc/BRIEF.md
# Prefix-Reordering Fetch Stage

This stage sits between an instruction fetch buffer and a single decoder on a one-wide machine. Instructions arrive as a stream of 32-bit words, each tagged as either a prefix or a base word. An instruction is written in memory as zero or more prefixes followed by one base word. The stage rearranges each such group so that the base word always leaves first. The decoder therefore finds the opcode in a fixed slot and never has to shift its window.

Leading prefixes are pushed onto a small last-in first-out stack. When the base word arrives it goes straight to the output register, marked as the start of a group. The stored prefixes then follow, popped one per output transfer, so the prefix written closest to the base word comes out first. For example, `PA PB WC` leaves as `WC PB PA`. A word with no prefixes passes through alone. If more prefixes arrive than the stack can hold, the stage reports an error and discards the whole group. A synchronous flush drops any partial or pending group.

Top module: `pfx_reorder`

## Requirements
- R1: After reset, `out_valid` is 0, `err` is 0 and `in_ready` is 1.
- R2: A base word (`in_pfx`=0) with no pending prefixes is presented unchanged on `out_word` with `out_first`=1 and `out_last`=1. It is transferred on the output one cycle after its input transfer.
- R3: Base words with no prefixes, sent back to back while `out_ready` stays 1, are accepted and delivered at one word per cycle.
- R4: For a group of prefixes followed by a base word, the base word comes out first with `out_first`=1. The prefixes follow in the reverse of their arrival order with `out_first`=0. Only the final word of the group carries `out_last`=1.
- R5: While the output presents a word that is not the last of its group, `in_ready` is 0.
- R6: While the output holds a word that has not been transferred (`out_ready`=0), `in_ready` is 0 and no new word reaches the output.
- R7: A group with exactly `DEPTH` prefixes (4 by default) is delivered whole and reordered.
- R8: A prefix that arrives when `DEPTH` prefixes are already pending raises `err` for exactly one cycle. That prefix, the prefixes before it and every following word up to and including the group's base word are discarded, and nothing is output for that group. The next group is handled normally.
- R9: A cycle with `flush`=1 discards pending prefixes and any word held at the output. `out_valid` and `err` are 0 after that clock edge, and a later base word comes out alone with `out_first`=1 and `out_last`=1.
- R10: While `out_valid`=1 and `out_ready`=0, `out_word`, `out_first` and `out_last` hold their values until the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous discard of all pending words |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Stage accepts the input word this cycle |
| in_word | input | W | Instruction word from fetch |
| in_pfx | input | 1 | 1 when the input word is a prefix |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Decoder takes the output word this cycle |
| out_word | output | W | Reordered instruction word |
| out_first | output | 1 | Word is the base word opening a group |
| out_last | output | 1 | Word closes its group |
| err | output | 1 | One-cycle pulse: prefix stack overflow, group dropped |

## Verification
A wrong stack pointer shows up within the group it corrupts. Prefixes come out in the wrong order, a stale prefix from an earlier or flushed group is appended, or `out_last` lands on the wrong word. All of these are visible as soon as the group's last transfer completes. A stuck drain or drop flag shows up as `in_ready` held low, or as a following plain word vanishing, within a few cycles of the next input. The bench therefore compares every delivered word and its flags against an ordering computed from the input sequence. It also checks the timing of the first transfer and the behaviour of `in_ready` during drains and stalls.

// File: rtl/pfx_reorder.sv
module pfx_reorder #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  input  logic         in_pfx,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word,
  output logic         out_first,
  output logic         out_last,
  output logic         err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  stk [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;
  logic          drn;
  logic          drop;

  assign in_ready = !flush && !drn && (!out_valid || out_ready);

  wire in_fire   = in_valid && in_ready;
  wire out_fire  = out_valid && out_ready;
  wire full      = (cnt == CW'(DEPTH));
  wire take_base = in_fire && !in_pfx && !drop;
  wire take_pfx  = in_fire && in_pfx && !drop && !full;
  wire ovf       = in_fire && in_pfx && !drop && full;

  assign cnt_m1 = cnt - CW'(1);
  wire [W-1:0] top = stk[cnt_m1[AW-1:0]];

  always_ff @(posedge clk)
    if (take_pfx) stk[cnt[AW-1:0]] <= in_word;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt       <= '0;
      drn       <= 1'b0;
      drop      <= 1'b0;
      out_valid <= 1'b0;
      err       <= 1'b0;
      if (!rst_n) begin
        out_word  <= '0;
        out_first <= 1'b0;
        out_last  <= 1'b0;
      end
    end else begin
      err <= ovf;
      if (ovf) begin
        drop <= 1'b1;
        cnt  <= '0;
      end else if (drop && in_fire && !in_pfx) begin
        drop <= 1'b0;
      end
      if (take_pfx) cnt <= cnt + CW'(1);
      if (drn && out_fire) begin
        out_word  <= top;
        out_first <= 1'b0;
        out_last  <= (cnt == CW'(1));
        drn       <= (cnt != CW'(1));
        cnt       <= cnt_m1;
      end else if (take_base) begin
        out_valid <= 1'b1;
        out_word  <= in_word;
        out_first <= 1'b1;
        out_last  <= (cnt == '0);
        drn       <= (cnt != '0);
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_word) && $stable(out_first) && $stable(out_last)));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !err));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready && in_pfx));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  base_then_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_first && !out_last && !flush) |=> (out_valid && !out_first));
endmodule

// File: tb/pfx_reorder_bench.sv
module pfx_reorder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        in_pfx = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_first;
  logic        out_last;
  logic        err;

  pfx_reorder #(.W(32), .DEPTH(4)) u_pfx_reorder (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_pfx(in_pfx),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_first(out_first), .out_last(out_last), .err(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] got_w [32];
  logic        got_f [32];
  logic        got_l [32];
  int          got_c [32];
  int          n = 0;
  int          in_c0 = -1;
  int          err_seen = 0;
  int          r5_bad = 0;
  int          stall_bad = 0;
  logic        stall_chk = 1'b0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_word = '0;
  logic        bp_en = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung act=%0d exp<=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) if (bp_en) begin #2; out_ready = ~out_ready; end

  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready && in_c0 < 0) in_c0 = cyc;
    if (out_valid && out_ready && n < 32) begin
      got_w[n] = out_word; got_f[n] = out_first; got_l[n] = out_last; got_c[n] = cyc;
      n = n + 1;
    end
    if (err) err_seen = err_seen + 1;
    if (out_valid && !out_last && in_ready) r5_bad = r5_bad + 1;
    if (stall_chk && prev_stall && !(out_valid && out_word == prev_word)) stall_bad = stall_bad + 1;
    prev_stall = out_valid && !out_ready;
    prev_word  = out_word;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int i, input logic [31:0] w, input logic f, input logic l, input string req);
    chk(got_w[i] === w, req, got_w[i], w);
    chk(got_f[i] === f && got_l[i] === l, req, {got_f[i], got_l[i]}, {f, l});
  endtask

  task automatic clear_log();
    n = 0; in_c0 = -1; err_seen = 0; r5_bad = 0; stall_bad = 0;
  endtask

  task automatic align();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [31:0] w, input logic p);
    in_word = w; in_pfx = p; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    align();
  endtask

  task automatic pulse_flush();
    align();
    flush = 1'b1;
    align();
    flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(err === 1'b0, "R1 err", err, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_plain();
    align(); clear_log(); out_ready = 1'b1;
    put(32'hA0, 0); put(32'hA1, 0); put(32'hA2, 0);
    settle();
    chk(n == 3, "R3 count", n, 3);
    expect_word(0, 32'hA0, 1, 1, "R2 plain");
    expect_word(1, 32'hA1, 1, 1, "R3 plain");
    expect_word(2, 32'hA2, 1, 1, "R3 plain");
    chk(got_c[0] == in_c0 + 1, "R2 latency", got_c[0], in_c0 + 1);
    chk(got_c[1] == got_c[0] + 1 && got_c[2] == got_c[1] + 1, "R3 rate", got_c[2] - got_c[0], 2);
  endtask

  task automatic t_group();
    align(); clear_log(); out_ready = 1'b1;
    put(32'hB1, 1); put(32'hB2, 1); put(32'hB3, 0);
    put(32'hC0, 0);
    settle();
    chk(n == 4, "R4 count", n, 4);
    expect_word(0, 32'hB3, 1, 0, "R4 base");
    expect_word(1, 32'hB2, 0, 0, "R4 near prefix");
    expect_word(2, 32'hB1, 0, 1, "R4 far prefix");
    expect_word(3, 32'hC0, 1, 1, "R4 next group");
    chk(r5_bad == 0, "R5 ready in drain", r5_bad, 0);
  endtask

  task automatic t_full();
    align(); clear_log(); stall_chk = 1'b1; bp_en = 1'b1;
    put(32'hD1, 1); put(32'hD2, 1); put(32'hD3, 1); put(32'hD4, 1); put(32'hD5, 0);
    repeat (20) @(negedge clk);
    bp_en = 1'b0; #3; out_ready = 1'b1;
    settle(); stall_chk = 1'b0;
    chk(n == 5, "R7 count", n, 5);
    expect_word(0, 32'hD5, 1, 0, "R7 base");
    expect_word(1, 32'hD4, 0, 0, "R7 p4");
    expect_word(2, 32'hD3, 0, 0, "R7 p3");
    expect_word(3, 32'hD2, 0, 0, "R7 p2");
    expect_word(4, 32'hD1, 0, 1, "R7 p1");
    chk(stall_bad == 0, "R10 hold", stall_bad, 0);
    chk(r5_bad == 0, "R5 ready in drain", r5_bad, 0);
  endtask

  task automatic t_stall();
    align(); clear_log(); stall_chk = 1'b1; out_ready = 1'b0;
    put(32'hE0, 0);
    in_word = 32'hE1; in_pfx = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R6 in_ready", in_ready, 0);
      chk(out_valid === 1'b1 && out_word === 32'hE0, "R6 out held", out_word, 32'hE0);
    end
    align(); out_ready = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    align(); in_valid = 1'b0;
    settle(); stall_chk = 1'b0;
    chk(n == 2, "R6 count", n, 2);
    expect_word(0, 32'hE0, 1, 1, "R6 first");
    expect_word(1, 32'hE1, 1, 1, "R6 second");
    chk(stall_bad == 0, "R10 hold", stall_bad, 0);
  endtask

  task automatic t_overflow();
    align(); clear_log(); out_ready = 1'b1;
    for (int k = 0; k < 5; k++) put(32'hF0 + k, 1);
    put(32'hF9, 0);
    settle();
    chk(n == 0, "R8 group dropped", n, 0);
    chk(err_seen == 1, "R8 err pulse", err_seen, 1);
    put(32'h77, 0);
    settle();
    chk(n == 1, "R8 recovery count", n, 1);
    expect_word(0, 32'h77, 1, 1, "R8 recovery");
    chk(err_seen == 1, "R8 err once", err_seen, 1);
  endtask

  task automatic t_flush();
    align(); clear_log(); out_ready = 1'b1;
    put(32'h51, 1); put(32'h52, 1);
    pulse_flush();
    put(32'h55, 0);
    settle();
    chk(n == 1, "R9 stale prefixes", n, 1);
    expect_word(0, 32'h55, 1, 1, "R9 after flush");
    clear_log(); out_ready = 1'b0;
    put(32'h66, 0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R9 held before", out_valid, 1);
    pulse_flush();
    @(negedge clk);
    chk(out_valid === 1'b0 && err === 1'b0, "R9 cleared", {out_valid, err}, 0);
    align(); out_ready = 1'b1;
    settle();
    chk(n == 0, "R9 nothing out", n, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_plain();
    t_group();
    t_full();
    t_stall();
    t_overflow();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule